// File: doc/BRIEF.md
# Microsequenced 8-bit Accumulator Processor

This block is a small 8-bit processor built around an accumulator. It reads single-byte opcodes from an internal byte-wide memory. Some opcodes are followed by a 16-bit address operand, stored least significant byte first. A control state machine walks through fetch, operand and execute micro-steps. Each clock performs one group of register transfers among the program counter, address register, data register, temporary register, instruction register, accumulator and the auxiliary operand register.

Before a run, the environment fills the memory through a load port. While that port is active, the processor is frozen. When the load enable drops, execution starts at address 0x0000.

Every memory read follows the same path:

- the program counter is copied into the address register;
- the addressed byte lands in the data register while the counter steps by one.

Operand addresses are assembled from two such reads. The first byte is parked in the temporary register, and the second byte stays in the data register. The pair `{data, temp}` then drives either the address register (for a load) or the program counter (for a jump). Results leave through an output register qualified by a one-cycle strobe. A halt opcode stops the machine until reset.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, all registers clear asynchronously. `out_data` reads 0x00, `out_valid` and `halted` read 0, and the program counter starts at 0x0000.
- R2: While `load_en` is high, each clock writes `load_data` into memory at `load_addr`. The processor holds all of its state: no output strobe, and `halted` does not change.
- R3: Fetching an opcode takes four clocks: address register from PC, data register from memory with PC+1, instruction register from data register, then decode. PC advances by one for every byte read.
- R4: Opcode 0x01 is followed by an address, low byte first. It loads the accumulator from that address and takes 12 clocks in total.
- R5: Opcode 0x03 copies the accumulator into the auxiliary register and takes 5 clocks.
- R6: Opcode 0x08 adds the auxiliary register to the accumulator modulo 256 and takes 5 clocks.
- R7: Opcode 0x07 puts the accumulator on `out_data` and raises `out_valid` for exactly one clock, in its fifth clock. `out_data` then holds until the next such opcode.
- R8: Opcode 0x00 sets `halted` after its fourth clock. `halted` stays high until reset, and no further output strobe appears.
- R9: Opcode 0x05 is followed by an address, low byte first. It loads that address into PC and takes 10 clocks; execution continues at the target.
- R10: Any other opcode value does nothing except consume its four fetch clocks.
- R11: Only the low `MEM_AW` address bits select a memory byte, so addresses differing only above them alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Memory preload enable; freezes execution |
| load_addr | input | ADDR_W | Preload byte address |
| load_data | input | DATA_W | Preload byte |
| out_data | output | DATA_W | Output register |
| out_valid | output | 1 | One-clock strobe for a new output value |
| halted | output | 1 | Processor has executed a halt |

## Verification
The bench builds the processor with `MEM_AW` set to 8. This gives a 256-byte memory, so an operand whose high byte is 0x01 aliases onto page zero. Byte order and the upper-bit masking are then both observable from the output value.

A sweep over a grid of operand pairs runs the load/copy/add/output/halt program for each pair. Each run checks the sum against arithmetic done in the bench, the exact clock of the strobe and the exact clock of the halt. Separate programs cover a forward jump over a halt, and unused opcodes followed by two output operations.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [7:0] {
    OP_HALT = 8'h00,
    OP_LDA  = 8'h01,
    OP_MOVR = 8'h03,
    OP_JMP  = 8'h05,
    OP_OUT  = 8'h07,
    OP_ADD  = 8'h08
  } opcode_e;

  typedef enum logic [4:0] {
    S_F1, S_F2, S_F3, S_DEC,
    S_A1, S_A2, S_A3, S_A4, S_A5,
    S_L1, S_L2, S_L3,
    S_JMP, S_MOVR, S_ADD, S_OUT, S_HLT
  } state_e;

  typedef struct packed {
    logic ar_from_pc;
    logic ar_from_op;
    logic dr_ld;
    logic pc_inc;
    logic pc_jmp;
    logic ir_ld;
    logic tr_ld;
    logic ac_from_dr;
    logic ac_add;
    logic r_ld;
    logic out_ld;
  } ctl_t;

endpackage

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
  parameter int DATA_W = 8,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [MEM_AW-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DATA_W-1:0] ir,
  output ctl_t              ctl,
  output state_e            state,
  output logic              halted
);
  state_e nxt;

  always_comb begin
    nxt = state;
    ctl = '0;
    unique case (state)
      S_F1:   begin ctl.ar_from_pc = 1'b1; nxt = S_F2; end
      S_F2:   begin ctl.dr_ld = 1'b1; ctl.pc_inc = 1'b1; nxt = S_F3; end
      S_F3:   begin ctl.ir_ld = 1'b1; nxt = S_DEC; end
      S_DEC: begin
        case (ir)
          OP_HALT:        nxt = S_HLT;
          OP_LDA, OP_JMP: nxt = S_A1;
          OP_MOVR:        nxt = S_MOVR;
          OP_ADD:         nxt = S_ADD;
          OP_OUT:         nxt = S_OUT;
          default:        nxt = S_F1;
        endcase
      end
      S_A1:   begin ctl.ar_from_pc = 1'b1; nxt = S_A2; end
      S_A2:   begin ctl.dr_ld = 1'b1; ctl.pc_inc = 1'b1; nxt = S_A3; end
      S_A3:   begin ctl.tr_ld = 1'b1; nxt = S_A4; end
      S_A4:   begin ctl.ar_from_pc = 1'b1; nxt = S_A5; end
      S_A5: begin
        ctl.dr_ld  = 1'b1;
        ctl.pc_inc = 1'b1;
        nxt = (ir == OP_JMP) ? S_JMP : S_L1;
      end
      S_L1:   begin ctl.ar_from_op = 1'b1; nxt = S_L2; end
      S_L2:   begin ctl.dr_ld = 1'b1; nxt = S_L3; end
      S_L3:   begin ctl.ac_from_dr = 1'b1; nxt = S_F1; end
      S_JMP:  begin ctl.pc_jmp = 1'b1; nxt = S_F1; end
      S_MOVR: begin ctl.r_ld = 1'b1; nxt = S_F1; end
      S_ADD:  begin ctl.ac_add = 1'b1; nxt = S_F1; end
      S_OUT:  begin ctl.out_ld = 1'b1; nxt = S_F1; end
      S_HLT:  nxt = S_HLT;
      default: nxt = S_F1;
    endcase
    if (!run) begin
      ctl = '0;
      nxt = state;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= S_F1;
    else if (run) state <= nxt;
  end

  assign halted = (state == S_HLT);
endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] ar,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);
  logic [DATA_W-1:0] dr, tr, ac, r;
  logic [ADDR_W-1:0] op_addr;

  assign op_addr = ADDR_W'({dr, tr});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pc <= '0;
    else if (ctl.pc_inc)     pc <= pc + 1'b1;
    else if (ctl.pc_jmp)     pc <= op_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ar <= '0;
    else if (ctl.ar_from_pc) ar <= pc;
    else if (ctl.ar_from_op) ar <= op_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dr <= '0;
    else if (ctl.dr_ld) dr <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tr <= '0;
    else if (ctl.tr_ld) tr <= dr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ir <= '0;
    else if (ctl.ir_ld) ir <= dr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ac <= '0;
    else if (ctl.ac_from_dr) ac <= dr;
    else if (ctl.ac_add)     ac <= ac + r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        r <= '0;
    else if (ctl.r_ld) r <= ac;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= ctl.out_ld;
      if (ctl.out_ld) out_data <= ac;
    end
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              halted
);
  logic              run;
  ctl_t              ctl;
  state_e            state;
  logic [ADDR_W-1:0] ar, pc;
  logic [DATA_W-1:0] ir, mem_rdata;

  assign run = ~load_en;

  acc_cpu_ram #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_ram (
    .clk   (clk),
    .we    (load_en),
    .waddr (load_addr[MEM_AW-1:0]),
    .wdata (load_data),
    .raddr (ar[MEM_AW-1:0]),
    .rdata (mem_rdata)
  );

  acc_cpu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .ir     (ir),
    .ctl    (ctl),
    .state  (state),
    .halted (halted)
  );

  acc_cpu_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .ar        (ar),
    .pc        (pc),
    .ir        (ir),
    .out_data  (out_data),
    .out_valid (out_valid)
  );
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input state_e            state,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] ar,
  input logic              out_valid,
  input logic              halted
);
  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (state == S_F2)) |=> (pc == $past(pc) + 1'b1));

  // R3
  ar_from_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (state == S_F1)) |=> (ar == $past(pc)));

  // R2
  load_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(pc) && $stable(ar)));

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !out_valid);
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .state     (state),
  .pc        (pc),
  .ar        (ar),
  .out_valid (out_valid),
  .halted    (halted)
);

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;
  localparam int MEM_AW = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load_en = 1'b1;
  logic [ADDR_W-1:0] load_addr = '0;
  logic [DATA_W-1:0] load_data = '0;
  logic [DATA_W-1:0] out_data;
  logic              out_valid;
  logic              halted;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc;
  int n_out;
  int out_val [4];
  int out_cyc [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .out_data(out_data), .out_valid(out_valid),
    .halted(halted)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    load_en = 1'b1;
    rst_n   = 1'b0;
    @(negedge clk);
    rst_n   = 1'b1;
  endtask

  task automatic poke(input int addr, input int data);
    @(negedge clk);
    load_en   = 1'b1;
    load_addr = ADDR_W'(addr);
    load_data = DATA_W'(data);
  endtask

  task automatic run_prog(input int limit);
    @(negedge clk);
    load_en = 1'b0;
    cyc = 0;
    n_out = 0;
    while (!halted && cyc < limit) begin
      @(posedge clk);
      #1;
      cyc++;
      if (out_valid && n_out < 4) begin
        out_val[n_out] = int'(out_data);
        out_cyc[n_out] = cyc;
        n_out++;
      end
    end
  endtask

  task automatic after_halt(input string req, input int last);
    int extra = 0;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk);
      #1;
      if (out_valid || !halted) extra++;
    end
    chk({req, " halted quiet"}, extra, 0);
    chk({req, " out held"}, int'(out_data), last);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    #1;
    chk("R1 out_data", int'(out_data), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 halted", int'(halted), 0);
    do_reset();

    // R2 R4 R5 R6 R7 R8 R11: sweep of the add program over operand grid
    for (int a = 0; a < 256; a += 15) begin
      for (int b = 0; b < 256; b += 37) begin
        do_reset();
        poke(0, 8'h01); poke(1, 8'h10); poke(2, 8'h00);
        poke(3, 8'h03);
        // R11: 0x0111 aliases 0x11 with 8 address bits
        poke(4, 8'h01); poke(5, 8'h11); poke(6, 8'h01);
        poke(7, 8'h08);
        poke(8, 8'h07);
        poke(9, 8'h00);
        poke(16'h10, a);
        poke(16'h11, b);
        poke(16'h00ff, 8'h00);
        // R2: held while loading, even though loading continued for many clocks
        #1;
        chk("R2 no strobe during load", int'(out_valid), 0);
        chk("R2 not halted during load", int'(halted), 0);
        run_prog(200);
        chk("R6 R11 sum", (n_out > 0) ? out_val[0] : -1, (a + b) % 256);
        chk("R7 strobe count", n_out, 1);
        chk("R4 R5 R6 R7 strobe clock", (n_out > 0) ? out_cyc[0] : -1, 39);
        chk("R8 halt clock", cyc, 43);
        if (a == 0 && b == 0) after_halt("R8", 0);
      end
    end

    // R9 jump over a halt, R1 start at address zero
    do_reset();
    poke(0, 8'h05); poke(1, 8'h07); poke(2, 8'h00);
    poke(3, 8'h00);
    poke(7, 8'h01); poke(8, 8'h20); poke(9, 8'h00);
    poke(10, 8'h07);
    poke(11, 8'h00);
    poke(16'h20, 8'h5a);
    run_prog(200);
    chk("R9 jump output", (n_out > 0) ? out_val[0] : -1, 8'h5a);
    chk("R9 strobe clock", (n_out > 0) ? out_cyc[0] : -1, 27);
    chk("R9 halt clock", cyc, 31);
    after_halt("R9", 8'h5a);

    // R10 unknown opcodes, R7 two outputs with hold
    do_reset();
    poke(0, 8'h02); poke(1, 8'hff);
    poke(2, 8'h01); poke(3, 8'h20); poke(4, 8'h00);
    poke(5, 8'h07);
    poke(6, 8'h03);
    poke(7, 8'h08);
    poke(8, 8'h07);
    poke(9, 8'h00);
    poke(16'h20, 8'h33);
    run_prog(200);
    chk("R10 first output", (n_out > 0) ? out_val[0] : -1, 8'h33);
    chk("R10 first strobe clock", (n_out > 0) ? out_cyc[0] : -1, 25);
    chk("R7 second output", (n_out > 1) ? out_val[1] : -1, 8'h66);
    chk("R7 second strobe clock", (n_out > 1) ? out_cyc[1] : -1, 40);
    chk("R10 halt clock", cyc, 44);
    after_halt("R7", 8'h66);

    // R1 reset clears a halted machine
    do_reset();
    #1;
    chk("R1 halted cleared", int'(halted), 0);
    chk("R1 out cleared", int'(out_data), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule